// File: doc/BRIEF.md
# Multi-Channel Shared-Counter PWM Timer

The block is a register-mapped timer with one up-counter that all of its output channels share. The counter runs from zero up to a programmable modulo value and then wraps to zero. A power-of-two prescaler sits in front of the counter and stretches each count step. Every channel compares the shared count against its own compare value and drives an edge-aligned PWM pin. The pin can be active-high, active-low or held low.

Software uses a simple bus with a word address and separate write and read strobes. Read data is combinational and is valid in the same cycle as the read strobe. Modulo and compare writes are applied at once while the counter is stopped. While the counter runs, these writes are held in a shadow register and become active at the next wrap, so a period is never cut short. Software can read back the active value to find out when the new setting has taken effect. Changes to a channel's mode bits reach the pin at once. Each channel also has a sticky match flag that software clears by writing 1 to it.

Top module: `pwm_timer_hub`

## Requirements
- R1: After reset the registers read as follows: the parameter register (0x04) returns the channel count in bits [7:0], control (0x10) reads 0, the count (0x14) reads 0, modulo (0x18) reads 0xFFFF, and every channel control word and compare value reads 0. All PWM pins are low.
- R2: The control register at 0x10 holds the prescale select in bits [2:0], the clock mode in bits [4:3] and a stored-only alignment bit in bit 5. All three fields read back exactly as written.
- R3: With clock mode 01 and prescale select P, one full counter period lasts (modulo+1)·2^P clock cycles.
- R4: The live count reads at 0x14. In clock mode 01 it steps by one up to the active modulo value and then wraps to 0.
- R5: While the clock mode is 00, a write to modulo (0x18) or to a channel compare (0x24+8n) reads back the new value on the next cycle.
- R6: While the counter runs, a modulo or compare write leaves the read-back (active) value unchanged. The written value becomes active at the next wrap, and the count reads 0 at that point.
- R7: The channel control word lives at 0x20+8n. Its fields are: flag in bit 7, edge-mode select in bit 5, a stored mode bit in bit 4, and the level field in bits [3:2]. With bit 5 = 1 and level 10, the pin is high while count < active compare and low otherwise. A compare of 0 gives a constant low pin, and a compare above modulo gives a constant high pin.
- R8: With bit 5 = 1 and level 01, the pin is the complement of the R7 level.
- R9: Level codes 00 and 11, or bit 5 = 0, hold the pin low.
- R10: A write to a channel control word changes the pin by the cycle after the write, without waiting for a wrap.
- R11: The channel flag sets when the count steps onto the active compare value. Writing 1 to bit 7 clears it, writing 0 leaves it set, and it stays clear while the counter is stopped.
- R12: Clock mode 00 freezes the count at its current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; read data is zero when low |
| addr | input | ADDR_W (8) | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr and rd_en |
| pwm_out | output | NCH (4) | One PWM pin per channel |

## Verification
The properties take two things for granted: a reset precedes operation, and the bus touches at most one register per cycle. The count-step and flag properties also assume that the prescale select changes only while the counter is stopped, so that count steps come at regular intervals. The stimulus keeps to this: the prescale select is written only together with clock mode 00, and the counter is started by a separate write. The bench sweeps every combination of three prescale settings and three modulo values. For each combination it tries every compare value from zero to one past modulo, with one channel in normal polarity and one inverted. Pin levels and period lengths are computed from the live count read over the bus.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  localparam int OFS_PARAM  = 32'h04;
  localparam int OFS_GLOBAL = 32'h08;
  localparam int OFS_CTRL   = 32'h10;
  localparam int OFS_COUNT  = 32'h14;
  localparam int OFS_MODULO = 32'h18;
  localparam int OFS_CH0    = 32'h20;
  localparam int CH_STRIDE  = 8;

  localparam logic [1:0] CLKMODE_STOP = 2'b00;
  localparam logic [1:0] CLKMODE_RUN  = 2'b01;

  localparam logic [1:0] LVL_HIGH_TRUE = 2'b10;
  localparam logic [1:0] LVL_LOW_TRUE  = 2'b01;

  typedef struct packed {
    logic       edge_sel;
    logic       aux_sel;
    logic [1:0] level;
  } ch_mode_t;

  function automatic int ch_ctl_ofs(input int idx);
    return OFS_CH0 + CH_STRIDE * idx;
  endfunction

  function automatic int ch_cmp_ofs(input int idx);
    return OFS_CH0 + CH_STRIDE * idx + 4;
  endfunction

  function automatic logic mode_drives(input ch_mode_t m);
    return m.edge_sel && ((m.level == LVL_HIGH_TRUE) || (m.level == LVL_LOW_TRUE));
  endfunction

endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] ps_sel,
  output logic            tick
);

  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] step_mask;

  always_comb begin
    step_mask = ~({DIV_W{1'b1}} << ps_sel);
    div_d     = run ? div_q + 1'b1 : '0;
    tick      = run && ((div_q & step_mask) == step_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             stopped,
  input  logic             mod_wr,
  input  logic [CNT_W-1:0] mod_wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic [CNT_W-1:0] mod_act_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mod_buf_q, mod_act_q, mod_act_d;
  logic             cnt_en, buf_en, act_en, wrap;

  always_comb begin
    wrap      = tick && (cnt_q >= mod_act_q);
    cnt_en    = tick;
    cnt_d     = wrap ? '0 : cnt_q + 1'b1;
    buf_en    = mod_wr;
    act_en    = (mod_wr && stopped) || wrap;
    mod_act_d = mod_wr ? mod_wdata : mod_buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      mod_buf_q <= '1;
      mod_act_q <= '1;
    end else begin
      if (cnt_en) cnt_q     <= cnt_d;
      if (buf_en) mod_buf_q <= mod_wdata;
      if (act_en) mod_act_q <= mod_act_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_en ? cnt_d : cnt_q;
  assign mod_act_o = mod_act_q;
  assign wrap_o    = wrap;

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((cnt_q == '0) || (cnt_q == $past(cnt_q) + 1'b1)));

  // R12
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R5
  mod_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && mod_wr) |=> (mod_act_q == $past(mod_wdata)));

  // R6
  mod_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && !wrap) |=> $stable(mod_act_q));

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrap,
  input  logic             stopped,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [7:0]       ctl_rd,
  output logic [CNT_W-1:0] cmp_rd,
  output logic             pin
);

  ch_mode_t         mode_q, mode_d;
  logic             flag_q, flag_d;
  logic [CNT_W-1:0] cmp_buf_q, cmp_act_q, cmp_act_d, cmp_act_nxt;
  logic             cmp_act_en, flag_set, flag_clr, drive, invert, below;
  logic [2:0]       unused_ctl;

  assign unused_ctl = {ctl_wdata[6], ctl_wdata[1:0]};

  always_comb begin
    mode_d      = '{edge_sel: ctl_wdata[5], aux_sel: ctl_wdata[4], level: ctl_wdata[3:2]};
    cmp_act_en  = (cmp_wr && stopped) || wrap;
    cmp_act_d   = cmp_wr ? cmp_wdata : cmp_buf_q;
    cmp_act_nxt = cmp_act_en ? cmp_act_d : cmp_act_q;
    flag_set    = tick && (cnt_nxt == cmp_act_nxt);
    flag_clr    = ctl_wr && ctl_wdata[7];
    flag_d      = flag_set || (flag_q && !flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      flag_q    <= 1'b0;
      cmp_buf_q <= '0;
      cmp_act_q <= '0;
    end else begin
      if (ctl_wr)     mode_q    <= mode_d;
      flag_q <= flag_d;
      if (cmp_wr)     cmp_buf_q <= cmp_wdata;
      if (cmp_act_en) cmp_act_q <= cmp_act_d;
    end
  end

  always_comb begin
    drive  = mode_drives(mode_q);
    invert = (mode_q.level == LVL_LOW_TRUE);
    below  = (cnt < cmp_act_q);
    pin    = drive && (below ^ invert);
    ctl_rd = {flag_q, 1'b0, mode_q.edge_sel, mode_q.aux_sel, mode_q.level, 2'b00};
    cmp_rd = cmp_act_q;
  end

  // R11
  flag_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (cnt == cmp_act_q));

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(ctl_wr && ctl_wdata[7])) |=> flag_q);

  // R6
  cmp_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && !wrap) |=> $stable(cmp_act_q));

  // R5
  cmp_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && cmp_wr) |=> (cmp_act_q == $past(cmp_wdata)));

endmodule

// File: rtl/pwm_timer_hub.sv
module pwm_timer_hub
  import pwmt_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCH-1:0]    pwm_out
);

  localparam logic [ADDR_W-1:0] A_PARAM  = ADDR_W'(OFS_PARAM);
  localparam logic [ADDR_W-1:0] A_GLOBAL = ADDR_W'(OFS_GLOBAL);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_MODULO = ADDR_W'(OFS_MODULO);
  localparam int CTRL_W = PS_W + 3;

  logic [1:0]       rst_sync_q;
  logic             rst_sn;
  logic [PS_W-1:0]  ps_q;
  logic [1:0]       clkmode_q;
  logic             align_q;
  logic             ctrl_wr, mod_wr, stopped, run, tick, wrap;
  logic [CNT_W-1:0] cnt, cnt_nxt, mod_act;
  logic [NCH-1:0][7:0]       ch_ctl_rd;
  logic [NCH-1:0][CNT_W-1:0] ch_cmp_rd;
  logic [31:0]      unused_wdata;

  assign unused_wdata = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  always_comb begin
    ctrl_wr = wr_en && (addr == A_CTRL);
    mod_wr  = wr_en && (addr == A_MODULO);
    stopped = (clkmode_q == CLKMODE_STOP);
    run     = (clkmode_q == CLKMODE_RUN);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ps_q      <= '0;
      clkmode_q <= CLKMODE_STOP;
      align_q   <= 1'b0;
    end else if (ctrl_wr) begin
      ps_q      <= wdata[PS_W-1:0];
      clkmode_q <= wdata[PS_W+1:PS_W];
      align_q   <= wdata[PS_W+2];
    end
  end

  pwmt_prescale #(.PS_W(PS_W)) u_prescale (
    .clk    (clk),
    .rst_n  (rst_sn),
    .run    (run),
    .ps_sel (ps_q),
    .tick   (tick)
  );

  pwmt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_sn),
    .tick      (tick),
    .stopped   (stopped),
    .mod_wr    (mod_wr),
    .mod_wdata (wdata[CNT_W-1:0]),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .mod_act_o (mod_act),
    .wrap_o    (wrap)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ch_ctl_ofs(gi));
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(ch_cmp_ofs(gi));
    pwmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_sn),
      .tick      (tick),
      .wrap      (wrap),
      .stopped   (stopped),
      .cnt       (cnt),
      .cnt_nxt   (cnt_nxt),
      .ctl_wr    (wr_en && (addr == A_CTL)),
      .ctl_wdata (wdata[7:0]),
      .cmp_wr    (wr_en && (addr == A_CMP)),
      .cmp_wdata (wdata[CNT_W-1:0]),
      .ctl_rd    (ch_ctl_rd[gi]),
      .cmp_rd    (ch_cmp_rd[gi]),
      .pin       (pwm_out[gi])
    );
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_PARAM:  rdata = 32'(NCH[7:0]);
        A_GLOBAL: rdata = '0;
        A_CTRL:   rdata = 32'({align_q, clkmode_q, ps_q});
        A_COUNT:  rdata = 32'(cnt);
        A_MODULO: rdata = 32'(mod_act);
        default:  rdata = '0;
      endcase
      for (int i = 0; i < NCH; i++) begin
        if (addr == ADDR_W'(ch_ctl_ofs(i))) rdata = 32'(ch_ctl_rd[i]);
        if (addr == ADDR_W'(ch_cmp_ofs(i))) rdata = 32'(ch_cmp_rd[i]);
      end
    end
  end

  // R2
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ctrl_wr |=> (32'({align_q, clkmode_q, ps_q}) == 32'($past(wdata[CTRL_W-1:0]))));

  // R12
  stop_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    stopped |-> !tick);

endmodule

// File: tb/pwm_timer_hub_tb_top.sv
`timescale 1ns/1ps
module pwm_timer_hub_tb_top;

  localparam int NCH = 4;
  localparam logic [7:0] A_PARAM = 8'h04, A_CTRL = 8'h10, A_CNT = 8'h14, A_MOD = 8'h18;
  localparam logic [7:0] A_CTL0 = 8'h20, A_CMP0 = 8'h24, A_CTL1 = 8'h28, A_CMP1 = 8'h2C;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] pwm_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pwm_timer_hub dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic run_cfg(input int ps, input int md, input int c0);
    logic [31:0] c, prev;
    int c1, wraps, t_first, limit;
    c1 = md + 1 - c0;
    wr(A_CTRL, 32'(ps));
    wr(A_MOD, 32'(md));
    wr(A_CMP0, 32'(c0));
    wr(A_CMP1, 32'(c1));
    wr(A_CTL0, 32'h28);
    wr(A_CTL1, 32'h24);
    wr(A_CTRL, 32'(8 | ps));
    wraps = 0; t_first = 0; prev = 0;
    limit = 4 * ((md + 1) << ps) + 8;
    for (int k = 0; k < limit; k++) begin
      rd(A_CNT, c);
      if (k > 0) begin
        chk("R4 step", 32'((c == prev) || (c == prev + 1) || (c == 0)), 1);
        if (c == 0 && prev != 0) begin
          wraps++;
          if (wraps == 1) t_first = k;
          else if (wraps == 2) chk("R3 period", 32'(k - t_first), 32'((md + 1) << ps));
        end
      end
      if (wraps >= 1) chk("R4 range", 32'(c <= md), 1);
      chk("R7 normal pin", 32'(pwm_out[0]), 32'(c < c0));
      chk("R8 inverted pin", 32'(pwm_out[1]), 32'(!(c < c1)));
      chk("R9 idle pins", 32'(pwm_out[3:2]), 0);
      prev = c;
    end
    chk("R4 wraps seen", 32'(wraps >= 2), 1);
    wr(A_CTRL, 32'(ps));
  endtask

  initial begin
    logic [31:0] v, v2;
    bit seen;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(A_PARAM, v); chk("R1 param", v, NCH);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_CNT, v);   chk("R1 count", v, 0);
    rd(A_MOD, v);   chk("R1 modulo", v, 32'hFFFF);
    rd(A_CTL0, v);  chk("R1 ch ctl", v, 0);
    rd(A_CMP1, v);  chk("R1 ch cmp", v, 0);
    chk("R1 pins", 32'(pwm_out), 0);

    // R2 control fields
    wr(A_CTRL, 32'h25); rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h25);
    wr(A_CTRL, 32'h03); rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h03);

    // R5 stopped writes are immediate
    wr(A_CTRL, 0);
    wr(A_MOD, 9);   rd(A_MOD, v);  chk("R5 modulo now", v, 9);
    wr(A_CMP0, 6);  rd(A_CMP0, v); chk("R5 compare now", v, 6);

    // R3 R4 R7 R8 R9 sweep
    for (int ps = 0; ps < 3; ps++)
      for (int mi = 0; mi < 3; mi++) begin
        int md;
        md = (mi == 0) ? 2 : (mi == 1) ? 3 : 5;
        for (int c0 = 0; c0 <= md + 1; c0++) run_cfg(ps, md, c0);
      end

    // R6 buffered updates while running
    wr(A_CTRL, 32'h02);
    wr(A_MOD, 7);
    wr(A_CMP0, 6);
    wr(A_CTRL, 32'h0A);
    seen = 0;
    for (int k = 0; k < 100 && !seen; k++) begin rd(A_CNT, v); if (v == 1) seen = 1; end
    chk("R6 reached count 1", 32'(seen), 1);
    wr(A_MOD, 4);
    wr(A_CMP0, 2);
    rd(A_MOD, v);  chk("R6 modulo still old", v, 7);
    rd(A_CMP0, v); chk("R6 compare still old", v, 6);
    seen = 0;
    for (int k = 0; k < 200 && !seen; k++) begin rd(A_MOD, v); if (v == 4) seen = 1; end
    chk("R6 modulo loaded", 32'(seen), 1);
    rd(A_CMP0, v);  chk("R6 compare loaded", v, 2);
    rd(A_CNT, v2);  chk("R6 load at wrap", v2, 0);

    // R12 stop freezes the count
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h02);
    rd(A_CNT, v);
    repeat (10) @(negedge clk);
    rd(A_CNT, v2); chk("R12 count held", v2, v);

    // R10 R9 immediate mode changes
    wr(A_MOD, 5); wr(A_CMP0, 7); wr(A_CTRL, 32'h08);
    wr(A_CTL0, 32'h28); chk("R10 normal high", 32'(pwm_out[0]), 1);
    wr(A_CTL0, 32'h24); chk("R10 inverted low", 32'(pwm_out[0]), 0);
    wr(A_CTL0, 32'h20); chk("R9 level 00 low", 32'(pwm_out[0]), 0);
    wr(A_CTL0, 32'h28); chk("R10 back high", 32'(pwm_out[0]), 1);
    wr(A_CTL0, 32'h2C); chk("R9 level 11 low", 32'(pwm_out[0]), 0);
    wr(A_CTL0, 32'h08); chk("R9 no edge mode low", 32'(pwm_out[0]), 0);

    // R11 match flag
    wr(A_CTRL, 0);
    wr(A_CTL0, 32'hA8);
    rd(A_CTL0, v); chk("R11 flag cleared", v, 32'h28);
    wr(A_CMP0, 3); wr(A_CTRL, 32'h08);
    seen = 0;
    for (int k = 0; k < 20 && !seen; k++) begin rd(A_CTL0, v); if (v[7]) seen = 1; end
    chk("R11 flag sets on match", 32'(seen), 1);
    wr(A_CTRL, 0);
    wr(A_CTL0, 32'h28); rd(A_CTL0, v); chk("R11 write 0 keeps flag", v, 32'hA8);
    wr(A_CTL0, 32'hA8); rd(A_CTL0, v); chk("R11 write 1 clears", v, 32'h28);
    repeat (5) @(negedge clk);
    rd(A_CTL0, v); chk("R11 stays clear stopped", v, 32'h28);

    finish_run();
  end

endmodule